// File: doc/BRIEF.md
# Debounced Level Interrupt Bank

This block watches a bank of eight input-only lines. Each line is synchronized to the system clock. It then goes through its own debounce filter, which counts strobes from an external 1 kHz timebase. A new level on a line is accepted only after it has held steady for the number of milliseconds programmed for that line. The accepted level is compared with a per-line active level. A match produces a pending interrupt bit, but only while that line's one-shot trigger is armed.

Software works through a flat 32-bit register window. It reads the filtered data and sets the data-visibility mask, the active level and the interrupt enable. It reads the raw and masked pending bits, clears pending bits and arms the triggers. Each line also has its own debounce word. Triggering is level-only. Each capture disarms its line, so software must re-arm the line after servicing it. One interrupt output is the OR of all enabled pending bits.

In every per-line register, bit n belongs to line n. Register offsets are fixed:

| Register | Offset |
|---|---|
| data | 0x00 |
| visibility mask | 0x04 |
| active level | 0x14 |
| enable | 0x18 |
| raw pending | 0x1C |
| masked pending | 0x20 |
| clear | 0x24 |
| arm | 0x28 |
| debounce word for line n | 0x40 + 4n |

Top module: `dbnc_irq_bank`

## Requirements
- R1: After reset every register reads 0, every accepted level is 0 and `irq_out` is low.
- R2: A line's accepted level takes the synchronized input value on the Nth `tick_1ms` strobe counted while the two differ. N is the line's debounce field. If the input returns to the accepted level before the Nth strobe, the count restarts from zero.
- R3: The debounce word for line n sits at 0x40+4n. Only bits 11:0 are stored and read back, and the other bits read 0. A field value of 0 behaves as 1.
- R4: Bit n of the data register (0x00) shows line n's accepted level when bit n of the visibility mask (0x04) is 1. Otherwise it reads 0.
- R5: Raw pending bit n (0x1C) is set when line n is armed and its accepted level equals active-level bit n (0x14), where 1 selects high and 0 selects low. An unarmed line never sets its pending bit.
- R6: A capture clears the line's arm bit (0x28, readable). Writing 1 to that bit re-arms the line.
- R7: Masked pending (0x20) equals raw pending ANDed with enable (0x18). `irq_out` is high exactly when any masked pending bit is set.
- R8: Writing 1 to bit n of the clear register (0x24) drops pending bit n, and writing 0 leaves it unchanged. A clear that lands in the same cycle as a capture on that line leaves the bit set.
- R9: An accepted level changes only in a cycle where `tick_1ms` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1ms | input | 1 | One-cycle strobe, once per millisecond |
| pin_in | input | NCH | Raw external lines |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | AW | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| irq_out | output | 1 | OR of all masked pending bits |

## Verification
A pin change reaches the synchronizer output two clocks later. From then on, only strobes count toward acceptance. The bench therefore waits three clocks after each pin change before issuing any strobe, and reads the data register at the falling edge after the strobe that should complete the count. A register write takes effect at the next rising edge and reads are combinational. A capture lands in the raw pending bit one edge after the arm write that enables it, so pending, arm and interrupt are sampled two clocks after that write. For the clear-versus-capture case, the clear is issued on the very edge where the capture occurs.

// File: rtl/dbnc_irq_bank.sv
module dbnc_irq_bank #(
  parameter int NCH = 8,
  parameter int TW  = 12,
  parameter int AW  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick_1ms,
  input  logic [NCH-1:0] pin_in,
  input  logic           bus_wr,
  input  logic [AW-1:0]  bus_addr,
  input  logic [31:0]    bus_wdata,
  output logic [31:0]    bus_rdata,
  output logic           irq_out
);

  localparam logic [AW-1:0] A_DATA = AW'(8'h00);
  localparam logic [AW-1:0] A_VMSK = AW'(8'h04);
  localparam logic [AW-1:0] A_LVL  = AW'(8'h14);
  localparam logic [AW-1:0] A_ENA  = AW'(8'h18);
  localparam logic [AW-1:0] A_RAW  = AW'(8'h1C);
  localparam logic [AW-1:0] A_MSK  = AW'(8'h20);
  localparam logic [AW-1:0] A_CLR  = AW'(8'h24);
  localparam logic [AW-1:0] A_ARM  = AW'(8'h28);
  localparam logic [AW-1:0] A_DBN  = AW'(8'h40);
  localparam int PADW = 32 - NCH;

  logic [NCH-1:0] sync1, sync2, acc;
  logic [NCH-1:0] vmsk, actlvl, ena, pend, armed;
  logic [NCH-1:0] hit, cap;
  logic [TW-1:0]  dcfg [NCH];

  assign hit     = ~(acc ^ actlvl);
  assign cap     = hit & armed;
  assign irq_out = |(pend & ena);

  wire w_vmsk = bus_wr && bus_addr == A_VMSK;
  wire w_lvl  = bus_wr && bus_addr == A_LVL;
  wire w_ena  = bus_wr && bus_addr == A_ENA;
  wire w_clr  = bus_wr && bus_addr == A_CLR;
  wire w_arm  = bus_wr && bus_addr == A_ARM;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1  <= '0;
      sync2  <= '0;
      vmsk   <= '0;
      actlvl <= '0;
      ena    <= '0;
      pend   <= '0;
      armed  <= '0;
    end else begin
      sync1 <= pin_in;
      sync2 <= sync1;
      if (w_vmsk) vmsk   <= bus_wdata[NCH-1:0];
      if (w_lvl)  actlvl <= bus_wdata[NCH-1:0];
      if (w_ena)  ena    <= bus_wdata[NCH-1:0];
      pend  <= (pend & ~(w_clr ? bus_wdata[NCH-1:0] : '0)) | cap;
      armed <= (w_arm ? bus_wdata[NCH-1:0] : armed) & ~cap;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [TW-1:0] cfg_q, cnt_q;
    logic          acc_q;
    logic [TW:0]   lim, nxt;
    wire w_cfg = bus_wr && bus_addr == A_DBN + AW'(4 * i);
    assign lim     = (cfg_q == '0) ? (TW+1)'(1) : {1'b0, cfg_q};
    assign nxt     = {1'b0, cnt_q} + (TW+1)'(1);
    assign acc[i]  = acc_q;
    assign dcfg[i] = cfg_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_q <= '0;
        cnt_q <= '0;
        acc_q <= 1'b0;
      end else begin
        if (w_cfg) cfg_q <= bus_wdata[TW-1:0];
        if (sync2[i] == acc_q) begin
          cnt_q <= '0;
        end else if (tick_1ms) begin
          if (nxt >= lim) begin
            acc_q <= sync2[i];
            cnt_q <= '0;
          end else begin
            cnt_q <= nxt[TW-1:0];
          end
        end
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_DATA: bus_rdata = {{PADW{1'b0}}, acc & vmsk};
      A_VMSK: bus_rdata = {{PADW{1'b0}}, vmsk};
      A_LVL:  bus_rdata = {{PADW{1'b0}}, actlvl};
      A_ENA:  bus_rdata = {{PADW{1'b0}}, ena};
      A_RAW:  bus_rdata = {{PADW{1'b0}}, pend};
      A_MSK:  bus_rdata = {{PADW{1'b0}}, pend & ena};
      A_ARM:  bus_rdata = {{PADW{1'b0}}, armed};
      default: begin
        for (int k = 0; k < NCH; k++)
          if (bus_addr == A_DBN + AW'(4 * k))
            bus_rdata = {{(32-TW){1'b0}}, dcfg[k]};
      end
    endcase
  end

  p_tick_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_1ms |=> $stable(acc));

  p_cap_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cap != '0) |=> ((pend & $past(cap)) == $past(cap)));

  p_cap_disarms_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((cap != '0) && !w_arm) |=> ((armed & $past(cap)) == '0));

  p_need_arm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & ~$past(pend) & ~$past(armed)) == '0));

  p_irq_needs_ena_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (ena != '0));

  p_hidden_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_DATA && vmsk == '0) |-> (bus_rdata == '0));

endmodule

// File: tb/dbnc_irq_bank_test.sv
module dbnc_irq_bank_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_1ms = 1'b0;
  logic [7:0]  pin_in = '0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbnc_irq_bank uut (
    .clk(clk), .rst_n(rst_n), .tick_1ms(tick_1ms), .pin_in(pin_in),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  function automatic logic [7:0] exp_raw(logic [7:0] lv, logic [7:0] pol, logic [7:0] arm);
    return ~(lv ^ pol) & arm;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; #1;
    d = bus_rdata;
  endtask

  task automatic tk();
    @(negedge clk);
    tick_1ms = 1'b1;
    @(posedge clk); #1;
    tick_1ms = 1'b0;
  endtask

  task automatic setpins(logic [7:0] p);
    @(negedge clk);
    pin_in = p;
    repeat (3) @(posedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [7:0] pol, vm, en, pins;
    void'($urandom(32'h1F2E3D4C));
    repeat (3) @(posedge clk);
    #1;
    chk("R1 irq", {31'd0, irq_out}, 32'd0);
    rst_n = 1'b1;
    begin
      logic [7:0] addrs [9] = '{8'h00, 8'h04, 8'h14, 8'h18, 8'h1C, 8'h20, 8'h28, 8'h40, 8'h5C};
      foreach (addrs[k]) begin
        rd(addrs[k], r);
        chk($sformatf("R1 reg %h", addrs[k]), r, 32'd0);
      end
    end

    // R2 / R9 debounce on line 0, length 3
    wr(8'h04, 32'hFF);
    wr(8'h40, 32'd3);
    setpins(8'h01);
    tk(); tk();
    rd(8'h00, r); chk("R2 before third strobe", r, 32'h0);
    tk();
    rd(8'h00, r); chk("R2 on third strobe", r, 32'h1);
    setpins(8'h00);
    tk(); tk();
    setpins(8'h01);
    setpins(8'h00);
    tk(); tk();
    rd(8'h00, r); chk("R2 restart after bounce", r, 32'h1);
    tk();
    rd(8'h00, r); chk("R2 accepted after restart", r, 32'h0);
    setpins(8'h01);
    repeat (10) @(posedge clk);
    rd(8'h00, r); chk("R9 no strobe no change", r, 32'h0);
    tk(); tk(); tk();

    // R3 field width and zero length on line 1
    wr(8'h44, 32'hABCDE123);
    rd(8'h44, r); chk("R3 field readback", r, 32'h123);
    wr(8'h44, 32'h0);
    rd(8'h44, r); chk("R3 zero readback", r, 32'h0);
    setpins(8'h03);
    tk();
    rd(8'h00, r); chk("R3 zero acts as one", r, 32'h3);

    // random level/config sweep (R4, R5, R6, R7)
    for (int it = 0; it < 24; it++) begin
      wr(8'h28, 32'h0);
      wr(8'h24, 32'hFF);
      for (int c = 0; c < 8; c++) wr(8'h40 + 8'(4*c), $urandom_range(0, 3));
      pol = 8'($urandom); vm = 8'($urandom); en = 8'($urandom); pins = 8'($urandom);
      wr(8'h14, {24'd0, pol});
      wr(8'h04, {24'd0, vm});
      wr(8'h18, {24'd0, en});
      setpins(pins);
      repeat (4) tk();
      rd(8'h00, r); chk("R4 gated data", r, {24'd0, pins & vm});
      rd(8'h1C, r); chk("R5 unarmed no pending", r, 32'h0);
      wr(8'h28, 32'hFF);
      repeat (2) @(posedge clk);
      rd(8'h1C, r); chk("R5 raw pending", r, {24'd0, exp_raw(pins, pol, 8'hFF)});
      rd(8'h28, r); chk("R6 arm after capture", r, {24'd0, ~exp_raw(pins, pol, 8'hFF)});
      rd(8'h20, r); chk("R7 masked", r, {24'd0, exp_raw(pins, pol, 8'hFF) & en});
      chk("R7 irq", {31'd0, irq_out}, {31'd0, |(exp_raw(pins, pol, 8'hFF) & en)});
    end

    // directed clear behaviour (R8) and re-arm (R6)
    wr(8'h28, 32'h0);
    wr(8'h14, 32'hFF);
    wr(8'h18, 32'h01);
    setpins(8'hFF);
    repeat (4) tk();
    wr(8'h24, 32'hFF);
    rd(8'h1C, r); chk("R8 cleared", r, 32'h0);
    wr(8'h28, 32'h01);
    repeat (2) @(posedge clk);
    rd(8'h1C, r); chk("R6 re-arm captures", r, 32'h1);
    chk("R7 irq single", {31'd0, irq_out}, 32'd1);
    wr(8'h24, 32'h0);
    rd(8'h1C, r); chk("R8 zero write ignored", r, 32'h1);
    wr(8'h24, 32'h1);
    repeat (2) @(posedge clk);
    rd(8'h1C, r); chk("R8 one write clears, disarmed stays clear", r, 32'h0);
    chk("R7 irq low", {31'd0, irq_out}, 32'd0);
    wr(8'h28, 32'h02);
    wr(8'h24, 32'h02);
    rd(8'h1C, r); chk("R8 clear with capture same cycle", r, 32'h2);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule